// File: doc/BRIEF.md
# Message-Converting Interrupt Controller

This block collects up to 64 interrupt input lines and turns them into a stream of messages. Each message carries an 8-bit vector number. A source becomes a message candidate when its trigger condition holds, it is unmasked and its message enable is set. A round-robin arbiter picks one candidate. The chosen vector is presented on a valid/ready output and held there until the receiver accepts it.

Software sets up the block over a simple 32-bit register bus with address, write data, write strobe, read strobe and read data. Read data appears one cycle after the read strobe.

Each source has the following per-source settings:
- a mask bit
- a message-enable bit
- a trigger-mode bit and a polarity bit, which together select one of four trigger kinds
- a vector byte
- a route byte, which is stored only

Two further pairs of words are plain storage. A write-one-to-clear register discards latched edges.

Top module: `msi_irq_ctrl`

## Requirements
- R1: After reset, both mask words read 0xFFFFFFFF. The enable, mode, polarity, vector, route and spare-storage registers read zero, and no message is valid.
- R2: Source n is controlled by bit n%32 of the word at base+4*(n/32). Word bases are: mask 0x20, enable 0x40, mode 0x60, clear 0x80, polarity 0x3E0. Vector bytes sit at 0x200+n and route bytes at 0x100+n, four per word, with byte n%4 at bits 8*(n%4)+7:8*(n%4). Route bytes and the spare words at 0xC0/0xC4/0xE0/0xE4 read back what was written.
- R3: A read of an address that is not mapped returns zero. This includes any address whose two low bits are not zero, and the write-only clear words. A write to such an address changes no register.
- R4: Mode and polarity select the trigger kind: mode=1,pol=0 rising edge; mode=1,pol=1 falling edge; mode=0,pol=0 high level; mode=0,pol=1 low level.
- R5: A source produces a message only while its mask bit is 0 and its enable bit is 1. An edge caught while the source is masked or disabled stays latched and is delivered once both allow it.
- R6: Writing 1 to a clear bit discards that source's latched edge. Writing 0 leaves the latch untouched.
- R7: The message vector equals the vector byte of the granted source.
- R8: Once valid is high, it stays high and the vector stays stable until ready is seen.
- R9: Accepting a message from an edge source clears that source's latch, so one edge produces exactly one message.
- R10: A level source produces one message per assertion. It produces another only after its input returns to the inactive level and becomes active again.
- R11: Arbitration is round-robin. After source i is granted, the next grant goes to the first candidate above i, wrapping from source 63 to source 0. After reset, source 0 has the highest priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 64 | Interrupt input lines, asynchronous |
| reg_addr_i | input | 10 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted by the receiver |
| msg_vec_o | output | 8 | Vector number of the presented message |

## Verification
The assertions assume that mask and enable change only through bus writes, so the grant they see was taken against the previous cycle's register values. They also assume that a source's input pulse lasts long enough to cross the two-flop synchronizer. The stimulus holds every input change for at least three clock cycles. It issues one bus operation at a time and never raises the write and read strobes together. It drives ready only at falling edges, so an accept always lands on a clean rising edge.

// File: rtl/msi_irq_pkg.sv
package msi_irq_pkg;
  localparam int unsigned BYTE_W   = 8;
  // register byte offsets
  localparam int unsigned OFF_MASK = 'h020;
  localparam int unsigned OFF_EN   = 'h040;
  localparam int unsigned OFF_MODE = 'h060;
  localparam int unsigned OFF_CLR  = 'h080;
  localparam int unsigned OFF_SPA  = 'h0C0;
  localparam int unsigned OFF_SPB  = 'h0E0;
  localparam int unsigned OFF_RTE  = 'h100;
  localparam int unsigned OFF_VEC  = 'h200;
  localparam int unsigned OFF_POL  = 'h3E0;
endpackage

// File: rtl/msi_irq_regs.sv
module msi_irq_regs
  import msi_irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic                    we_i,
  input  logic                    re_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic [N_SRC-1:0]        mask_o,
  output logic [N_SRC-1:0]        en_o,
  output logic [N_SRC-1:0]        mode_o,
  output logic [N_SRC-1:0]        pol_o,
  output logic [N_SRC-1:0]        clr_o,
  output logic [N_SRC*BYTE_W-1:0] vec_o
);
  localparam int unsigned NW   = N_SRC / DATA_W;
  localparam int unsigned BPW  = DATA_W / BYTE_W;
  localparam int unsigned NBW  = N_SRC / BPW;
  localparam int unsigned WI_W = ADDR_W - 2;

  logic [N_SRC-1:0]        mask_q, en_q, mode_q, pol_q;
  logic [NW*DATA_W-1:0]    spa_q, spb_q;
  logic [N_SRC*BYTE_W-1:0] rte_q, vec_q;
  logic [DATA_W-1:0]       rd_d, rdata_q;
  logic [WI_W-1:0]         widx;
  logic                    aligned;

  assign widx    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  function automatic logic hit(input logic [WI_W-1:0] a, input int unsigned base, input int unsigned k);
    return a == WI_W'((base >> 2) + k);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      spa_q  <= '0;
      spb_q  <= '0;
      rte_q  <= '0;
      vec_q  <= '0;
    end else if (we_i && aligned) begin
      for (int unsigned w = 0; w < NW; w++) begin
        if (hit(widx, OFF_MASK, w)) mask_q[w*DATA_W +: DATA_W] <= wdata_i;
        if (hit(widx, OFF_EN,   w)) en_q[w*DATA_W +: DATA_W]   <= wdata_i;
        if (hit(widx, OFF_MODE, w)) mode_q[w*DATA_W +: DATA_W] <= wdata_i;
        if (hit(widx, OFF_POL,  w)) pol_q[w*DATA_W +: DATA_W]  <= wdata_i;
        if (hit(widx, OFF_SPA,  w)) spa_q[w*DATA_W +: DATA_W]  <= wdata_i;
        if (hit(widx, OFF_SPB,  w)) spb_q[w*DATA_W +: DATA_W]  <= wdata_i;
      end
      for (int unsigned k = 0; k < NBW; k++) begin
        if (hit(widx, OFF_RTE, k)) rte_q[k*DATA_W +: DATA_W] <= wdata_i;
        if (hit(widx, OFF_VEC, k)) vec_q[k*DATA_W +: DATA_W] <= wdata_i;
      end
    end
  end

  // clear strobes are single-cycle, never stored
  always_comb begin
    clr_o = '0;
    if (we_i && aligned) begin
      for (int unsigned w = 0; w < NW; w++)
        if (hit(widx, OFF_CLR, w)) clr_o[w*DATA_W +: DATA_W] = wdata_i;
    end
  end

  always_comb begin
    rd_d = '0;
    if (aligned) begin
      for (int unsigned w = 0; w < NW; w++) begin
        if (hit(widx, OFF_MASK, w)) rd_d = mask_q[w*DATA_W +: DATA_W];
        if (hit(widx, OFF_EN,   w)) rd_d = en_q[w*DATA_W +: DATA_W];
        if (hit(widx, OFF_MODE, w)) rd_d = mode_q[w*DATA_W +: DATA_W];
        if (hit(widx, OFF_POL,  w)) rd_d = pol_q[w*DATA_W +: DATA_W];
        if (hit(widx, OFF_SPA,  w)) rd_d = spa_q[w*DATA_W +: DATA_W];
        if (hit(widx, OFF_SPB,  w)) rd_d = spb_q[w*DATA_W +: DATA_W];
      end
      for (int unsigned k = 0; k < NBW; k++) begin
        if (hit(widx, OFF_RTE, k)) rd_d = rte_q[k*DATA_W +: DATA_W];
        if (hit(widx, OFF_VEC, k)) rd_d = vec_q[k*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;
  assign mask_o  = mask_q;
  assign en_o    = en_q;
  assign mode_o  = mode_q;
  assign pol_o   = pol_q;
  assign vec_o   = vec_q;
endmodule

// File: rtl/msi_irq_src.sv
module msi_irq_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic mode_i,
  input  logic pol_i,
  input  logic clr_i,
  input  logic ack_i,
  output logic pend_o
);
  logic s1_q, s2_q, prev_q, latch_q, done_q;
  logic act, act_prev;

  // polarity applied to both samples so a polarity change alone makes no edge
  assign act      = s2_q ^ pol_i;
  assign act_prev = prev_q ^ pol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      s1_q   <= irq_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (mode_i && act && !act_prev) latch_q <= 1'b1;
      else if (clr_i || ack_i)        latch_q <= 1'b0;
      if (!act)                       done_q  <= 1'b0;
      else if (ack_i && !mode_i)      done_q  <= 1'b1;
    end
  end

  assign pend_o = mode_i ? latch_q : (act && !done_q);
endmodule

// File: rtl/msi_irq_rr.sv
module msi_irq_rr #(
  parameter int unsigned N  = 64,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          take_i,
  output logic          gnt_valid_o,
  output logic [IW-1:0] gnt_idx_o
);
  logic [IW-1:0] last_q, idx;
  logic          found;
  int unsigned   j;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    j     = 0;
    for (int unsigned k = 1; k <= N; k++) begin
      j = (int'(last_q) + k) % N;
      if (!found && req_i[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              last_q <= IW'(N - 1);
    else if (take_i && found) last_q <= idx;
  end

  assign gnt_valid_o = found;
  assign gnt_idx_o   = idx;
endmodule

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl
  import msi_irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [BYTE_W-1:0] msg_vec_o
);
  localparam int unsigned IW = $clog2(N_SRC);

  logic [N_SRC-1:0]        mask_w, en_w, mode_w, pol_w, clr_w, pend_w, elig_w, ack_vec;
  logic [N_SRC*BYTE_W-1:0] vec_w;
  logic                    gnt_valid, valid_q;
  logic [IW-1:0]           gnt_idx, idx_q;
  logic [BYTE_W-1:0]       vec_q;

  msi_irq_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .we_i    (reg_we_i),
    .re_i    (reg_re_i),
    .rdata_o (reg_rdata_o),
    .mask_o  (mask_w),
    .en_o    (en_w),
    .mode_o  (mode_w),
    .pol_o   (pol_w),
    .clr_o   (clr_w),
    .vec_o   (vec_w)
  );

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    msi_irq_src u_src (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .irq_i  (irq_i[n]),
      .mode_i (mode_w[n]),
      .pol_i  (pol_w[n]),
      .clr_i  (clr_w[n]),
      .ack_i  (ack_vec[n]),
      .pend_o (pend_w[n])
    );
  end

  assign elig_w = pend_w & ~mask_w & en_w;

  msi_irq_rr #(.N(N_SRC)) u_rr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (elig_w),
    .take_i      (!valid_q),
    .gnt_valid_o (gnt_valid),
    .gnt_idx_o   (gnt_idx)
  );

  assign ack_vec = (valid_q && msg_ready_i) ? (N_SRC'(1) << idx_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      vec_q   <= '0;
    end else if (!valid_q) begin
      if (gnt_valid) begin
        valid_q <= 1'b1;
        idx_q   <= gnt_idx;
        vec_q   <= vec_w[gnt_idx*BYTE_W +: BYTE_W];
      end
    end else if (msg_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign msg_valid_o = valid_q;
  assign msg_vec_o   = vec_q;
endmodule

// File: rtl/msi_irq_ctrl_chk.sv
module msi_irq_ctrl_chk #(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IW = $clog2(N_SRC)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_re_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              msg_valid_o,
  input logic              msg_ready_i,
  input logic [7:0]        msg_vec_o,
  input logic [N_SRC-1:0]  mask_w,
  input logic [N_SRC-1:0]  en_w,
  input logic [N_SRC-1:0]  ack_vec,
  input logic [IW-1:0]     idx_q
);
  logic [N_SRC-1:0] mask_d, en_d;
  logic             gap_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_d <= '1;
      en_d   <= '0;
    end else begin
      mask_d <= mask_w;
      en_d   <= en_w;
    end
  end

  assign gap_rd = reg_re_i && (32'(reg_addr_i) >= 32'h300) && (32'(reg_addr_i) < 32'h3E0);

  AST_VALID_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o); // R8
  AST_VEC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> $stable(msg_vec_o)); // R8
  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_vec)); // R9
  AST_GRANT_ALLOWED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |-> (!mask_d[idx_q] && en_d[idx_q])); // R5
  AST_GAP_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_rd |=> reg_rdata_o == '0); // R3
endmodule

bind msi_irq_ctrl msi_irq_ctrl_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_re_i    (reg_re_i),
  .reg_rdata_o (reg_rdata_o),
  .msg_valid_o (msg_valid_o),
  .msg_ready_i (msg_ready_i),
  .msg_vec_o   (msg_vec_o),
  .mask_w      (mask_w),
  .en_w        (en_w),
  .ack_vec     (ack_vec),
  .idx_q       (idx_q)
);

// File: tb/msi_irq_ctrl_test.sv
module msi_irq_ctrl_test;
  localparam int N = 64;
  // entry: {src[5:0], mode, pol, vector[7:0]}
  localparam logic [15:0] TBL [6] = '{
    {6'd0,  2'b10, 8'h11},
    {6'd31, 2'b11, 8'h22},
    {6'd32, 2'b00, 8'h33},
    {6'd63, 2'b01, 8'h44},
    {6'd5,  2'b10, 8'hA5},
    {6'd40, 2'b11, 8'h5A}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0, ready = 1'b0;
  logic [31:0] rdata;
  logic        valid;
  logic [7:0]  vec;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  logic [N-1:0]   mask_sh = '1, en_sh = '0, mode_sh = '0, pol_sh = '0;
  logic [N*8-1:0] vec_sh = '0;

  always #4 clk = ~clk;

  msi_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_we_i(we), .reg_re_i(re),
    .reg_rdata_o(rdata), .msg_valid_o(valid), .msg_ready_i(ready), .msg_vec_o(vec)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = 10'(a); wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); addr = 10'(a); re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(a, d);
    chk(d === exp, req, d, exp);
  endtask

  task automatic cfg(input int n, input bit m, input bit p, input logic [7:0] v, input bit msk, input bit e);
    int w = n / 32, b = n / 4;
    mode_sh[n] = m; pol_sh[n] = p; vec_sh[n*8 +: 8] = v; mask_sh[n] = msk; en_sh[n] = e;
    wr('h200 + 4*b, vec_sh[b*32 +: 32]);
    wr('h060 + 4*w, mode_sh[w*32 +: 32]);
    wr('h3E0 + 4*w, pol_sh[w*32 +: 32]);
    wr('h040 + 4*w, en_sh[w*32 +: 32]);
    wr('h020 + 4*w, mask_sh[w*32 +: 32]);
  endtask

  task automatic setm(input int n, input bit msk);
    mask_sh[n] = msk;
    wr('h020 + 4*(n/32), mask_sh[(n/32)*32 +: 32]);
  endtask

  task automatic sete(input int n, input bit e);
    en_sh[n] = e;
    wr('h040 + 4*(n/32), en_sh[(n/32)*32 +: 32]);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_msg(output bit got, output logic [7:0] v);
    got = 1'b0; v = '0;
    for (int i = 0; i < 16 && !got; i++) begin
      @(negedge clk);
      if (valid) begin got = 1'b1; v = vec; end
    end
  endtask

  task automatic accept();
    ready = 1'b1;
    @(negedge clk); ready = 1'b0;
  endtask

  task automatic no_msg(input int cyc, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (valid) seen = 1'b1;
    end
    chk(!seen, req, 32'(seen), 32'd0);
  endtask

  task automatic expect_msg(input logic [7:0] exp, input string req);
    bit got; logic [7:0] v;
    wait_msg(got, v);
    chk(got && v === exp, req, {23'd0, got, v}, {23'd0, 1'b1, exp});
    if (got) accept();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] e;
    int src;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(valid === 1'b0, "R1 valid", 32'(valid), 32'd0);
    rd_chk('h020, 32'hFFFF_FFFF, "R1 mask0");
    rd_chk('h024, 32'hFFFF_FFFF, "R1 mask1");
    rd_chk('h040, 32'h0, "R1 en");
    rd_chk('h064, 32'h0, "R1 mode");
    rd_chk('h3E4, 32'h0, "R1 pol");
    rd_chk('h23C, 32'h0, "R1 vec");
    rd_chk('h100, 32'h0, "R1 route");
    rd_chk('h0E4, 32'h0, "R1 spare");

    // storage and decode
    wr('h104, 32'h0101_0101);
    rd_chk('h104, 32'h0101_0101, "R2 route");
    wr('h0C4, 32'hDEAD_BEEF);
    rd_chk('h0C4, 32'hDEAD_BEEF, "R2 spare");
    wr('h0E0, 32'h1234_5678);
    rd_chk('h0E0, 32'h1234_5678, "R2 spare b");
    rd_chk('h300, 32'h0, "R3 unmapped");
    rd_chk('h080, 32'h0, "R3 clear reads zero");
    wr('h0C5, 32'hFFFF_FFFF);
    rd_chk('h0C4, 32'hDEAD_BEEF, "R3 misaligned write ignored");
    rd_chk('h0C5, 32'h0, "R3 misaligned read");

    // table of trigger kinds
    for (int i = 0; i < 6; i++) begin
      bit got; logic [7:0] v;
      e = TBL[i];
      src = int'(e[15:10]);
      irq[src] = e[8];
      settle();
      cfg(src, e[9], e[8], e[7:0], 1'b0, 1'b1);
      rd_chk('h200 + 4*(src/4), vec_sh[(src/4)*32 +: 32], "R2 vector byte lane");
      no_msg(6, "R4 idle input quiet");
      irq[src] = ~e[8];
      wait_msg(got, v);
      chk(got, "R4 trigger kind", 32'(got), 32'd1);
      chk(v === e[7:0], "R7 vector", 32'(v), 32'(e[7:0]));
      if (got) accept();
      no_msg(8, e[9] ? "R9 single message per edge" : "R10 single message per level");
      irq[src] = e[8];
      settle();
      setm(src, 1'b1);
      sete(src, 1'b0);
    end

    // mask keeps the latch
    cfg(3, 1'b1, 1'b0, 8'h77, 1'b1, 1'b1);
    irq[3] = 1'b1; settle(); irq[3] = 1'b0;
    no_msg(10, "R5 masked");
    setm(3, 1'b0);
    expect_msg(8'h77, "R5 delivered on unmask");

    // enable gating
    cfg(4, 1'b1, 1'b0, 8'h78, 1'b0, 1'b0);
    irq[4] = 1'b1; settle(); irq[4] = 1'b0;
    no_msg(10, "R5 disabled");
    sete(4, 1'b1);
    expect_msg(8'h78, "R5 delivered on enable");

    // clear register
    cfg(6, 1'b1, 1'b0, 8'h66, 1'b1, 1'b1);
    irq[6] = 1'b1; settle(); irq[6] = 1'b0; settle();
    wr('h080, 32'hFFFF_FFBF);
    setm(6, 1'b0);
    expect_msg(8'h66, "R6 zero bit no effect");
    setm(6, 1'b1);
    irq[6] = 1'b1; settle(); irq[6] = 1'b0; settle();
    wr('h080, 32'h0000_0040);
    setm(6, 1'b0);
    no_msg(10, "R6 clear discards");

    // hold until ready
    begin
      bit got; logic [7:0] v; bit held = 1'b1;
      cfg(7, 1'b1, 1'b0, 8'h99, 1'b0, 1'b1);
      irq[7] = 1'b1; settle(); irq[7] = 1'b0;
      wait_msg(got, v);
      chk(got && v === 8'h99, "R8 presented", 32'(v), 32'h99);
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (!(valid && vec === 8'h99)) held = 1'b0;
      end
      chk(held, "R8 held without ready", 32'(held), 32'd1);
      accept();
      chk(valid === 1'b0, "R8 dropped after ready", 32'(valid), 32'd0);
      no_msg(8, "R9 latch cleared on accept");
    end

    // level re-send
    cfg(33, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1);
    irq[33] = 1'b1;
    expect_msg(8'h3C, "R10 first assertion");
    no_msg(10, "R10 no repeat while held");
    irq[33] = 1'b0; settle();
    irq[33] = 1'b1;
    expect_msg(8'h3C, "R10 re-sent after return");
    irq[33] = 1'b0; settle();
    setm(33, 1'b1);

    // round robin
    cfg(10, 1'b1, 1'b0, 8'h0A, 1'b0, 1'b1);
    cfg(11, 1'b1, 1'b0, 8'h0B, 1'b0, 1'b1);
    cfg(12, 1'b1, 1'b0, 8'h0C, 1'b0, 1'b1);
    irq[11] = 1'b1; settle(); irq[11] = 1'b0;
    expect_msg(8'h0B, "R11 seed grant");
    irq[10] = 1'b1; irq[12] = 1'b1; settle(); irq[10] = 1'b0; irq[12] = 1'b0;
    expect_msg(8'h0C, "R11 next above last");
    expect_msg(8'h0A, "R11 then wrap order");
    irq[63] = 1'b0; settle();
    cfg(63, 1'b1, 1'b0, 8'h3F, 1'b0, 1'b1);
    cfg(5, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b1);
    irq[5] = 1'b1; irq[63] = 1'b1; settle(); irq[5] = 1'b0; irq[63] = 1'b0;
    expect_msg(8'h3F, "R11 top source before wrap");
    expect_msg(8'hA5, "R11 wrap to low source");
    rd('h024, d);
    chk(d === mask_sh[63:32], "R2 mask word1", d, mask_sh[63:32]);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule